// File: doc/BRIEF.md
# Bus Ownership Handover Arbiter

This block runs on the master side of a shared local bus. The master owns the bus by default and runs its own cycles. An external agent may ask for the bus by pulling an active-low request line. The arbiter lets the cycle in progress finish and holds the cycle engine idle. It then hands the bus over by driving an active-low grant, and it takes the address, data and control strobe drivers off the bus in a fixed order. When the request is withdrawn it brings the drivers back in the reverse order. It lets the cycle engine run again only after the request has been seen negated on two consecutive samples.

The request passes through a two-stage synchronizer. A saturating counter tracks how many consecutive samples have seen the request negated. A six-state machine drives the grant, the three output-enable groups, a strobe-quiet control that forces every strobe to its inactive level, and a stall signal for the cycle engine. The states are OWNED (master drives the bus), WAIT_END (request seen while a cycle is still running), GRANT (grant low, drivers still on, strobes quiet), RELEASED (only the grant is driven), REACQ_CTRL (grant high, strobe drivers back on, strobes quiet) and REACQ_BUS (address and data drivers back on). The transitions are: OWNED to GRANT when a request is seen at a cycle boundary, and OWNED to WAIT_END when a request is seen mid-cycle. WAIT_END goes to GRANT at the boundary. GRANT always goes to RELEASED. RELEASED goes to REACQ_CTRL when the request is seen negated. REACQ_CTRL always goes to REACQ_BUS. REACQ_BUS goes back to GRANT or WAIT_END if the request is seen again, and to OWNED otherwise.

Top module: `bus_handover_arb`

## Requirements
- R1: During and right after an asynchronous reset (rst_n low), grant_n is 1, addr_oe, data_oe and ctrl_oe are 1, and strobe_hold and eng_stall are 0.
- R2: req_in_n is sampled through two flops. If it goes low in the cycle after edge k, eng_stall is still 0 after edge k+1 and rises after edge k+2.
- R3: A cycle boundary is a cycle in which cyc_busy is 0 or cyc_last is 1. grant_n goes low on the first edge, counted from the edge that makes the request visible, that ends a boundary cycle. With the engine busy until a cycle whose cyc_last is 1, this is the edge at the end of that cycle.
- R4: eng_stall is 1 in every cycle from the one in which the synchronized request is first visible until the address and data enables are back on with two negated samples. It is 1 whenever grant_n is 0.
- R5: strobe_hold is 1 in the cycle in which grant_n first reads 0, which is the last cycle before ctrl_oe drops. It stays 1 while the bus is released and through REACQ_CTRL.
- R6: addr_oe, data_oe and ctrl_oe are all still 1 in the first cycle of grant_n = 0. All three go to 0 on the next edge.
- R7: On the edge where the negated request is first seen in RELEASED, grant_n goes to 1 and ctrl_oe to 1, while addr_oe stays 0 and strobe_hold stays 1.
- R8: addr_oe and data_oe return to 1 exactly one edge after grant_n returns to 1.
- R9: eng_stall goes low only after the synchronized request has been seen negated on at least two consecutive edges. A one-cycle request pulse during reacquire keeps the engine stalled for two more cycles, without a new grant.
- R10: A request that is visible in REACQ_BUS is taken at that cycle boundary. grant_n goes low on the next edge without the engine being released, and the enables drop one edge later.
- R11: addr_oe always equals data_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in_n | input | 1 | External bus request, active low, asynchronous |
| cyc_busy | input | 1 | Cycle engine is inside a bus cycle |
| cyc_last | input | 1 | Current cycle is the last of the bus cycle |
| grant_n | output | 1 | Bus grant to the external agent, active low |
| addr_oe | output | 1 | Output enable for the address bus |
| data_oe | output | 1 | Output enable for the data bus |
| ctrl_oe | output | 1 | Output enable for the control strobes |
| strobe_hold | output | 1 | Forces every control strobe to its inactive level |
| eng_stall | output | 1 | Holds the cycle engine idle |

## Verification
Two things can fall in the same cycle: the end of a running bus cycle and the arrival of the synchronized request. Re-entry of a request can also coincide with the reacquire steps. The bench sweeps the number of busy cycles before the boundary, from zero to well past the sync latency, so the boundary lands before, on and after the cycle in which the request becomes visible. It predicts every output in every cycle from the cycle count alone. Two further cases inject a request during reacquire: one held, which must lead to a fresh grant from REACQ_BUS, and one single-cycle pulse, which must only stretch the stall.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [2:0] {
        ST_OWNED      = 3'd0,
        ST_WAIT_END   = 3'd1,
        ST_GRANT      = 3'd2,
        ST_RELEASED   = 3'd3,
        ST_REACQ_CTRL = 3'd4,
        ST_REACQ_BUS  = 3'd5
    } arb_state_e;

    typedef struct packed {
        logic grant_n;
        logic addr_oe;
        logic data_oe;
        logic ctrl_oe;
        logic strobe_hold;
    } bus_drv_t;

    localparam bus_drv_t DRV_OWNED = '{grant_n: 1'b1, addr_oe: 1'b1, data_oe: 1'b1,
                                       ctrl_oe: 1'b1, strobe_hold: 1'b0};

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/bha_run_cnt.sv
module bha_run_cnt #(
    parameter int NEG_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_seen,
    output logic run_ok
);

    localparam int CW = $clog2(NEG_MIN + 1);
    localparam logic [CW-1:0] SAT = CW'(NEG_MIN);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= SAT;
        end else if (req_seen) begin
            run_q <= '0;
        end else if (run_q != SAT) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign run_ok = (run_q == SAT);

endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_seen,
    input  logic     cyc_boundary,
    input  logic     run_ok,
    output bus_drv_t drv,
    output logic     eng_stall
);

    arb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWNED: begin
                if (req_seen) state_d = cyc_boundary ? ST_GRANT : ST_WAIT_END;
            end
            ST_WAIT_END: begin
                if (cyc_boundary) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                state_d = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (!req_seen) state_d = ST_REACQ_CTRL;
            end
            ST_REACQ_CTRL: begin
                state_d = ST_REACQ_BUS;
            end
            ST_REACQ_BUS: begin
                if (req_seen) state_d = cyc_boundary ? ST_GRANT : ST_WAIT_END;
                else          state_d = ST_OWNED;
            end
            default: state_d = ST_OWNED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OWNED;
        else        state_q <= state_d;
    end

    always_comb begin
        drv       = DRV_OWNED;
        eng_stall = 1'b1;
        unique case (state_q)
            ST_OWNED: begin
                eng_stall = req_seen | ~run_ok;
            end
            ST_WAIT_END: begin
                drv.strobe_hold = 1'b0;
            end
            ST_GRANT: begin
                drv.grant_n     = 1'b0;
                drv.strobe_hold = 1'b1;
            end
            ST_RELEASED: begin
                drv.grant_n     = 1'b0;
                drv.addr_oe     = 1'b0;
                drv.data_oe     = 1'b0;
                drv.ctrl_oe     = 1'b0;
                drv.strobe_hold = 1'b1;
            end
            ST_REACQ_CTRL: begin
                drv.addr_oe     = 1'b0;
                drv.data_oe     = 1'b0;
                drv.strobe_hold = 1'b1;
            end
            ST_REACQ_BUS: begin
                eng_stall = req_seen | ~run_ok;
            end
            default: begin
                drv = DRV_OWNED;
            end
        endcase
    end

endmodule

// File: rtl/bus_handover_arb.sv
module bus_handover_arb
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NEG_MIN     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in_n,
    input  logic cyc_busy,
    input  logic cyc_last,
    output logic grant_n,
    output logic addr_oe,
    output logic data_oe,
    output logic ctrl_oe,
    output logic strobe_hold,
    output logic eng_stall
);

    logic     req_sync_n;
    logic     req_seen;
    logic     run_ok;
    logic     cyc_boundary;
    bus_drv_t drv;

    bha_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (req_in_n),
        .q_out (req_sync_n)
    );

    assign req_seen     = ~req_sync_n;
    assign cyc_boundary = ~cyc_busy | cyc_last;

    bha_run_cnt #(
        .NEG_MIN (NEG_MIN)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_seen (req_seen),
        .run_ok   (run_ok)
    );

    bha_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_seen     (req_seen),
        .cyc_boundary (cyc_boundary),
        .run_ok       (run_ok),
        .drv          (drv),
        .eng_stall    (eng_stall)
    );

    assign grant_n     = drv.grant_n;
    assign addr_oe     = drv.addr_oe;
    assign data_oe     = drv.data_oe;
    assign ctrl_oe     = drv.ctrl_oe;
    assign strobe_hold = drv.strobe_hold;

endmodule

// File: rtl/bha_chk.sv
module bha_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_busy,
    input logic cyc_last,
    input logic grant_n,
    input logic addr_oe,
    input logic data_oe,
    input logic ctrl_oe,
    input logic strobe_hold,
    input logic eng_stall
);

    // R6
    drivers_on_at_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n) |-> (addr_oe && data_oe && ctrl_oe));

    // R6
    drivers_off_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n) |=> (!addr_oe && !data_oe && !ctrl_oe));

    // R5
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_oe) |-> $past(strobe_hold));

    // R7
    ctrl_first_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_n) |-> (ctrl_oe && !addr_oe && strobe_hold));

    // R8
    bus_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_n) |=> (addr_oe && data_oe));

    // R4
    grant_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_n |-> eng_stall);

    // R3
    grant_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n) |-> $past(!cyc_busy || cyc_last));

    // R11
    addr_data_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe == data_oe);

endmodule

bind bus_handover_arb bha_chk u_chk (.*);

// File: tb/sim_bus_handover_arb.sv
`timescale 1ns/100ps
module sim_bus_handover_arb;

    logic clk = 1'b0;
    logic rst_n;
    logic req_in_n;
    logic cyc_busy;
    logic cyc_last;
    logic grant_n, addr_oe, data_oe, ctrl_oe, strobe_hold, eng_stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_handover_arb u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_in_n    (req_in_n),
        .cyc_busy    (cyc_busy),
        .cyc_last    (cyc_last),
        .grant_n     (grant_n),
        .addr_oe     (addr_oe),
        .data_oe     (data_oe),
        .ctrl_oe     (ctrl_oe),
        .strobe_hold (strobe_hold),
        .eng_stall   (eng_stall)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic settle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            req_in_n = 1'b1; cyc_busy = 1'b0; cyc_last = 1'b0;
        end
    endtask

    // One handover: engine busy for l cycles, request held h cycles past grant.
    task automatic sweep_case(input int l, input int h);
        int g, rn;
        g  = (l > 3) ? l : 3;
        rn = g + h;
        for (int n = 0; n <= rn + 6; n++) begin
            @(posedge clk); #1;
            req_in_n = (n >= rn);
            cyc_busy = (n < l);
            cyc_last = (n == l - 1);
            #1;
            check("R3", "grant_n", grant_n, !(n >= g && n <= rn + 2));
            check("R6", "ctrl_oe", ctrl_oe, !(n >= g + 1 && n <= rn + 2));
            check("R8", "addr_oe", addr_oe, !(n >= g + 1 && n <= rn + 3));
            check("R11", "data_oe", data_oe, !(n >= g + 1 && n <= rn + 3));
            check("R5", "strobe_hold", strobe_hold, (n >= g && n <= rn + 3));
            check((n <= 2) ? "R2" : "R4", "eng_stall", eng_stall, (n >= 2 && n <= rn + 3));
            if (n == rn + 3) begin
                check("R7", "ctrl back with grant high", ctrl_oe & grant_n & ~addr_oe, 1'b1);
            end
        end
    endtask

    // mode 0: request comes back and stays; mode 1: single-cycle request pulse
    task automatic reacq_case(input int mode);
        int rn;
        rn = 5;
        for (int n = 0; n <= rn + 6; n++) begin
            @(posedge clk); #1;
            cyc_busy = 1'b0;
            cyc_last = 1'b0;
            if (mode == 0) req_in_n = !(n < rn || n >= rn + 2);
            else           req_in_n = !(n < rn || n == rn + 1);
            #1;
            if (n == rn + 3) begin
                check("R7", "grant_n in ctrl reacquire", grant_n, 1'b1);
                check("R7", "addr_oe in ctrl reacquire", addr_oe, 1'b0);
            end
            if (n == rn + 4) begin
                check("R8", "addr_oe in bus reacquire", addr_oe, 1'b1);
                check(mode == 0 ? "R10" : "R9", "eng_stall in bus reacquire", eng_stall, 1'b1);
            end
            if (mode == 0 && n == rn + 5) begin
                check("R10", "grant_n after re-request", grant_n, 1'b0);
                check("R10", "addr_oe on re-grant", addr_oe, 1'b1);
                check("R10", "strobe_hold on re-grant", strobe_hold, 1'b1);
            end
            if (mode == 0 && n == rn + 6) begin
                check("R10", "addr_oe released again", addr_oe, 1'b0);
                check("R10", "ctrl_oe released again", ctrl_oe, 1'b0);
            end
            if (mode == 1 && n == rn + 5) begin
                check("R9", "eng_stall one negated sample", eng_stall, 1'b1);
                check("R9", "grant_n stays high", grant_n, 1'b1);
            end
            if (mode == 1 && n == rn + 6) begin
                check("R9", "eng_stall two negated samples", eng_stall, 1'b0);
                check("R9", "grant_n stays high", grant_n, 1'b1);
            end
        end
        settle(12);
        check("R4", "eng_stall back in owned", eng_stall, 1'b0);
        check("R8", "addr_oe back in owned", addr_oe, 1'b1);
    endtask

    initial begin
        rst_n    = 1'b0;
        req_in_n = 1'b0;
        cyc_busy = 1'b0;
        cyc_last = 1'b0;
        #12;
        check("R1", "grant_n in reset", grant_n, 1'b1);
        check("R1", "ctrl_oe in reset", ctrl_oe, 1'b1);
        check("R1", "eng_stall in reset", eng_stall, 1'b0);
        req_in_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1", "addr_oe after reset", addr_oe, 1'b1);
        check("R1", "data_oe after reset", data_oe, 1'b1);
        check("R1", "strobe_hold after reset", strobe_hold, 1'b0);
        check("R1", "grant_n after reset", grant_n, 1'b1);
        settle(4);
        for (int l = 0; l <= 6; l++) begin
            for (int h = 1; h <= 4; h++) begin
                sweep_case(l, h);
                settle(6);
            end
        end
        reacq_case(0);
        reacq_case(1);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        #10;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule